// File: doc/BRIEF.md
# Parity-Protected Branch Target Cache

This block stores the jump targets of branches the pipeline has already taken and offers them back as predictions when the same fetch address comes round again. It is direct-mapped: a word-aligned fetch address selects one slot through its low index bits, and the remaining upper bits form a tag that must match the stored one. When a branch resolves, an update port writes its target and tag into the slot selected by its address. A lookup port takes a fetch address and, one cycle later, reports a hit flag and the predicted target.

Each stored entry carries one even-parity bit over its tag and target. The bit is computed as the entry is written. Targets are word aligned, so the two low target bits are never stored, and the parity bit takes the place they free. If a lookup finds that the parity of the selected entry is wrong, the block reports a miss and a zero target. A corrupted target can therefore never steer fetch, and the pipeline falls back to normal branch resolution. A single-cycle input clears every entry. A test input inverts the stored parity bit of one chosen slot so that the suppression path can be exercised.

Top module: `btc_cache`

## Requirements
- R1: While reset is held, and after it is released, `lk_done`, `lk_hit` and `lk_target` are zero. Every entry starts invalid, so any lookup made before the first update misses.
- R2: A lookup request sampled on a rising edge produces `lk_done` high for exactly one cycle, in the cycle that follows. `lk_done` is never high without a request.
- R3: The slot index is fetch address bits [5:2] (16 slots) and the tag is bits [31:6]. A lookup hits only when the slot is valid, its stored tag equals the lookup tag, and its parity is good. An address with the same index but a different tag misses.
- R4: An update stores the given target and tag in the slot picked by the update address. A later update to the same slot replaces the earlier contents.
- R5: The parity bit written with an entry makes the XOR of the stored tag, the stored target bits [31:2] and the parity bit equal to zero (even parity). A freshly written entry therefore always checks good.
- R6: When the selected slot fails its parity check, `lk_hit` is 0 and `lk_target` is zero, whatever its tag and valid bit hold.
- R7: A lookup and a write (update or parity flip) to the same slot in the same cycle return the slot's old contents. The new contents are seen by a lookup in the next cycle.
- R8: `inval_all` makes every slot invalid in one cycle. It overrides an update presented in the same cycle, so that update is dropped.
- R9: `inject_valid` inverts the stored parity bit of slot `inject_idx`, and a second inversion restores a hit. If an update writes the same slot in the same cycle, the newly written parity bit is stored inverted.
- R10: `lk_target` is zero whenever `lk_hit` is 0. Its bits [1:0] are always zero, and the predicted target equals the update target with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 30 | Fetch word address, byte address bits [31:2] |
| upd_valid | input | 1 | Write a branch target |
| upd_addr | input | 30 | Branch word address, byte address bits [31:2] |
| upd_target | input | 30 | Target word address, byte address bits [31:2] |
| inval_all | input | 1 | Clear every valid bit |
| inject_valid | input | 1 | Invert one slot's stored parity bit (test use) |
| inject_idx | input | 4 | Slot whose parity bit is inverted |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | 32 | Predicted target byte address, zero on a miss |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 4-bit index. With only 16 slots, the bench can fill every slot, create aliases that share an index but differ in tag, and then wipe the whole array. With a 26-bit tag, aliases can be placed far apart in the address space, so a tag compare that is too narrow shows up as a false hit. The small slot count also lets the bench put a parity flip, an update and a lookup on the same slot in the same cycle, in every combination.

// File: rtl/btc_pkg.sv
package btc_pkg;

    // Targets and fetch addresses are word aligned: the low bits are implied.
    localparam int WORD_OFS_W = 2;

    // Per-slot action chosen for the coming clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_FILL = 2'd1,
        OP_WIPE = 2'd2
    } slot_op_e;

endpackage

// File: rtl/btc_parity_gen.sv
module btc_parity_gen #(
    parameter int W = 56
) (
    input  logic [W-1:0] data,
    output logic         par
);
    // Even parity: the parity bit makes the total count of ones even.
    always_comb begin
        par = ^data;
    end
endmodule

// File: rtl/btc_store.sv
module btc_store
    import btc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int TGT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             wr_par,
    input  logic             clr_all,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_par,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt
);
    localparam int SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [SLOTS-1:0]            valid;
        logic [SLOTS-1:0]            par;
        logic [SLOTS-1:0][TAG_W-1:0] tag;
        logic [SLOTS-1:0][TGT_W-1:0] tgt;
    } store_t;

    store_t                 st_d, st_q;
    slot_op_e [SLOTS-1:0]   op;
    logic     [SLOTS-1:0]   flip_sel;

    // Per-slot decode: a wipe outranks a fill, and a fill outranks a hold.
    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign op[g] = clr_all                                ? OP_WIPE :
                           (wr_en && (wr_idx == IDX_W'(g)))       ? OP_FILL :
                                                                    OP_HOLD;
            assign flip_sel[g] = flip_en && (flip_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            case (op[i])
                OP_WIPE: begin
                    st_d.valid[i] = 1'b0;
                end
                OP_FILL: begin
                    st_d.valid[i] = 1'b1;
                    st_d.tag[i]   = wr_tag;
                    st_d.tgt[i]   = wr_tgt;
                    st_d.par[i]   = wr_par;
                end
                default: begin
                end
            endcase
            // A test flip lands on top of whatever parity the slot ends with.
            st_d.par[i] = st_d.par[i] ^ flip_sel[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The read reflects state before this edge, so same-cycle writes stay hidden.
    always_comb begin
        rd_valid = st_q.valid[rd_idx];
        rd_par   = st_q.par[rd_idx];
        rd_tag   = st_q.tag[rd_idx];
        rd_tgt   = st_q.tgt[rd_idx];
    end
endmodule

// File: rtl/btc_match.sv
module btc_match #(
    parameter int TAG_W = 26,
    parameter int TGT_W = 30
) (
    input  logic             ent_valid,
    input  logic             ent_par,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TGT_W-1:0] ent_tgt,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic             par_err
);
    logic tag_eq;

    always_comb begin
        par_err = ^{ent_tag, ent_tgt, ent_par};
        tag_eq  = (ent_tag == look_tag);
        hit     = ent_valid && tag_eq && !par_err;
    end
endmodule

// File: rtl/btc_cache.sv
module btc_cache #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 lk_valid,
    input  logic [ADDR_W-1:btc_pkg::WORD_OFS_W]  lk_addr,
    input  logic                                 upd_valid,
    input  logic [ADDR_W-1:btc_pkg::WORD_OFS_W]  upd_addr,
    input  logic [ADDR_W-1:btc_pkg::WORD_OFS_W]  upd_target,
    input  logic                                 inval_all,
    input  logic                                 inject_valid,
    input  logic [IDX_W-1:0]                     inject_idx,
    output logic                                 lk_done,
    output logic                                 lk_hit,
    output logic [ADDR_W-1:0]                    lk_target
);
    localparam int OFS_W = btc_pkg::WORD_OFS_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int TGT_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic              done;
        logic              hit;
        logic [ADDR_W-1:0] tgt;
    } res_t;

    res_t res_d, res_q;

    logic [IDX_W-1:0] look_idx, upd_idx;
    logic [TAG_W-1:0] look_tag, upd_tag;
    logic             upd_par;
    logic             rd_valid, rd_par;
    logic [TAG_W-1:0] rd_tag;
    logic [TGT_W-1:0] rd_tgt;
    logic             m_hit, m_par_err;

    always_comb begin
        look_idx = lk_addr[OFS_W +: IDX_W];
        look_tag = lk_addr[ADDR_W-1 -: TAG_W];
        upd_idx  = upd_addr[OFS_W +: IDX_W];
        upd_tag  = upd_addr[ADDR_W-1 -: TAG_W];
    end

    btc_parity_gen #(
        .W (TAG_W + TGT_W)
    ) u_pgen (
        .data ({upd_tag, upd_target}),
        .par  (upd_par)
    );

    btc_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .TGT_W (TGT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_tag   (upd_tag),
        .wr_tgt   (upd_target),
        .wr_par   (upd_par),
        .clr_all  (inval_all),
        .flip_en  (inject_valid),
        .flip_idx (inject_idx),
        .rd_idx   (look_idx),
        .rd_valid (rd_valid),
        .rd_par   (rd_par),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt)
    );

    btc_match #(
        .TAG_W (TAG_W),
        .TGT_W (TGT_W)
    ) u_match (
        .ent_valid (rd_valid),
        .ent_par   (rd_par),
        .ent_tag   (rd_tag),
        .ent_tgt   (rd_tgt),
        .look_tag  (look_tag),
        .hit       (m_hit),
        .par_err   (m_par_err)
    );

    always_comb begin
        res_d      = '0;
        res_d.done = lk_valid;
        res_d.hit  = lk_valid && m_hit && !m_par_err;
        if (res_d.hit) begin
            res_d.tgt = {rd_tgt, {OFS_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        lk_done   = res_q.done;
        lk_hit    = res_q.hit;
        lk_target = res_q.tgt;
    end
endmodule

// File: rtl/btc_cache_chk.sv
module btc_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              inval_all,
    input logic              lk_done,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_target
);
    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done);

    // R2
    hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done |-> !lk_hit);

    // R10
    miss_zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));

    // R10
    aligned_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_target[1:0] == 2'b00);

    // R8
    wipe_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all ##1 lk_valid |=> !lk_hit);
endmodule

bind btc_cache btc_cache_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .inval_all (inval_all),
    .lk_done   (lk_done),
    .lk_hit    (lk_hit),
    .lk_target (lk_target)
);

// File: tb/btc_cache_test.sv
module btc_cache_test;
    localparam int SLOTS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:2] lk_addr = '0;
    logic        upd_valid = 1'b0;
    logic [31:2] upd_addr = '0;
    logic [31:2] upd_target = '0;
    logic        inval_all = 1'b0;
    logic        inject_valid = 1'b0;
    logic [3:0]  inject_idx = '0;
    logic        lk_done, lk_hit;
    logic [31:0] lk_target;

    always #5 clk = ~clk;

    btc_cache uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
        .inval_all(inval_all), .inject_valid(inject_valid), .inject_idx(inject_idx),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_target(lk_target)
    );

    typedef struct {
        bit          hit;
        logic [31:0] tgt;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          m_val[SLOTS];
    logic [25:0] m_tag[SLOTS];
    logic [31:0] m_tgt[SLOTS];
    bit          m_bad[SLOTS];

    // Driver: one cycle of stimulus; the expected result comes from the model's state before this edge.
    task automatic step(input bit lv, input logic [31:0] la, input bit uv, input logic [31:0] ua,
                        input logic [31:0] ut, input bit iv, input bit jv, input int ji, input string req);
        int   k;
        exp_t e;
        @(negedge clk);
        lk_valid     = lv;
        lk_addr      = la[31:2];
        upd_valid    = uv;
        upd_addr     = ua[31:2];
        upd_target   = ut[31:2];
        inval_all    = iv;
        inject_valid = jv;
        inject_idx   = 4'(ji);
        if (lv) begin
            k     = int'(la[5:2]);
            e.hit = m_val[k] && (m_tag[k] == la[31:6]) && !m_bad[k];
            e.tgt = e.hit ? m_tgt[k] : 32'h0;
            e.req = req;
            sb.push_back(e);
        end
        if (iv) begin
            for (int i = 0; i < SLOTS; i++) m_val[i] = 1'b0;
        end
        if (uv && !iv) begin
            k        = int'(ua[5:2]);
            m_val[k] = 1'b1;
            m_tag[k] = ua[31:6];
            m_tgt[k] = {ut[31:2], 2'b00};
            m_bad[k] = jv && (ji == k);
        end
        if (jv && !(uv && !iv && (int'(ua[5:2]) == ji))) begin
            m_bad[ji] = !m_bad[ji];
        end
    endtask

    task automatic look(input logic [31:0] a, input string req);
        step(1'b1, a, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 0, req);
    endtask

    task automatic upd(input logic [31:0] a, input logic [31:0] t);
        step(1'b0, 32'h0, 1'b1, a, t, 1'b0, 1'b0, 0, "");
    endtask

    task automatic flip(input int idx);
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, idx, "");
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 0, "");
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare every result against the oldest expected item.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && lk_done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 lk_done=%0b with no request, expected 0", lk_done);
            end else begin
                e = sb.pop_front();
                if (lk_hit !== e.hit || lk_target !== e.tgt) begin
                    errors++;
                    $display("FAIL %s hit=%0b target=%h expected hit=%0b target=%h",
                             e.req, lk_hit, lk_target, e.hit, e.tgt);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_bad[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        checks++;
        if (lk_done !== 1'b0 || lk_hit !== 1'b0 || lk_target !== 32'h0) begin
            errors++;
            $display("FAIL R1 done=%0b hit=%0b target=%h expected 0 0 0", lk_done, lk_hit, lk_target);
        end
        rst_n = 1'b1;

        // R1: nothing cached yet
        look(32'h0000_0000, "R1");
        look(32'h0000_100C, "R1");
        look(32'hFFFF_FFFC, "R1");

        // R4 R5: fresh entry hits with its target
        upd(32'h0000_100C, 32'h2000_0040);
        look(32'h0000_100C, "R4_R5");
        // R3: same index, other tag misses; other index misses
        look(32'h0000_204C, "R3");
        look(32'h8000_100C, "R3");
        look(32'h0000_1008, "R3");

        // R7: update and lookup of the same slot in one cycle
        step(1'b1, 32'h0000_1014, 1'b1, 32'h0000_1014, 32'h3000_0100, 1'b0, 1'b0, 0, "R7");
        look(32'h0000_1014, "R7");
        step(1'b1, 32'h0000_100C, 1'b1, 32'h0000_100C, 32'h4000_0080, 1'b0, 1'b0, 0, "R7");
        look(32'h0000_100C, "R4");

        // R6 R9: corrupted parity suppresses the hit; second flip restores it
        flip(3);
        look(32'h0000_100C, "R6_R9");
        flip(3);
        look(32'h0000_100C, "R9");

        // R9: flip during a write to the same slot stores bad parity
        step(1'b0, 32'h0, 1'b1, 32'h0000_301C, 32'h5000_0010, 1'b0, 1'b1, 7, "");
        look(32'h0000_301C, "R9");
        upd(32'h0000_301C, 32'h5000_0010);
        look(32'h0000_301C, "R9");

        // R7: flip and lookup of the same slot in one cycle sees old parity
        step(1'b1, 32'h0000_1014, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 5, "R7");
        look(32'h0000_1014, "R6");
        flip(5);

        // R10: low target bits dropped
        upd(32'h0000_0020, 32'h1234_5677);
        look(32'h0000_0020, "R10");

        // R4 R3: every slot filled and read back
        for (int i = 0; i < SLOTS; i++)
            upd(32'hABC0_0000 | (i << 2), 32'h8000_0000 + i * 32'h104);
        for (int i = 0; i < SLOTS; i++)
            look(32'hABC0_0000 | (i << 2), "R4");

        // R8: wipe with a same-cycle update and lookup; lookup sees old state
        step(1'b1, 32'hABC0_0014, 1'b1, 32'h0000_2024, 32'h6000_0000, 1'b1, 1'b0, 0, "R8");
        for (int i = 0; i < SLOTS; i++)
            look(32'hABC0_0000 | (i << 2), "R8");
        look(32'h0000_2024, "R8");

        repeat (3) idle();
        @(negedge clk);
        // R2: every request answered
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 pending=%0d expected 0", sb.size());
        end
        summary();
        $finish;
    end
endmodule